// File: doc/BRIEF.md
# Single-Frame Register-Mapped Network Interface

This block is a minimal network interface that a host processor drives one byte at a time through a 32-bit register bus. It holds at most one received frame and one frame under assembly for transmission, each in its own byte buffer of `MAX_FRAME` bytes (1514 by default). Received bytes arrive on a byte stream with start, valid and end markers. The assembled transmit frame leaves on a byte stream with a last marker. A level interrupt, a busy flag and a pair of fixed identification words complete the host view.

The host drains a received frame by reading the receive data register once per byte. Each such read lowers the receive count by one. To send, the host programs a transmit length and then writes bytes to the transmit data register. The frame goes out by itself as soon as the programmed length is reached. Busy is set by every completed receive or transmit and by reset. It is recomputed from the pending interrupt bits whenever the host writes the interrupt control register. A new receive frame is accepted only while busy is clear.

Top module: `sfnic_top`

## Requirements
- R1: Only `host_addr[5:0]` is decoded, so addresses 64 apart alias. Offset 0x00 reads 32'h4D495053 and offset 0x04 reads 32'h4E455430. Offset 0x08 reads busy in bit 0, 0x0C reads the receive count and 0x10 reads the transmit count. Offsets 0x18, 0x20 and every unmapped offset read 0.
- R2: A read request in one cycle gives `host_rvalid` high with its data in the next cycle. In any cycle with no read request before it, `host_rvalid` is low.
- R3: The interrupt control register (offset 0x14) has transmit-done in bit 0, receive-done in bit 1 and test in bit 31. `irq` is high exactly when any of these bits is set.
- R4: A write to 0x14 does one action, chosen by priority. If bit 0 is set, it clears transmit-done. Otherwise, if bit 1 is set, it clears receive-done. Otherwise, if bit 31 is set, it performs a soft reset. A write of 0 changes no bit. After any write to 0x14, busy equals the OR of the resulting interrupt bits.
- R5: A read of 0x14 returns the current bits and then clears the test bit.
- R6: `rxs_ready` is high only while busy is 0, no frame is being captured and the receive count is below `MAX_FRAME`. A frame whose start beat sees `rxs_ready` high is stored. When its end beat arrives, the receive count becomes the frame length, the read pointer returns to 0, busy becomes 1 and receive-done is set.
- R7: A frame is dropped if its start beat sees `rxs_ready` low, or if its length is `MAX_FRAME` or more. Each dropped frame increments `rx_drop_count`, which saturates at all ones and is cleared only by `rst_n`.
- R8: A read of 0x1C while the receive count is nonzero returns the next stored byte, zero-extended, and lowers the count by 1. With a count of 0, the read returns 0 and changes nothing.
- R9: A write to 0x10 loads the value if it is at most `MAX_FRAME` and loads 0 otherwise. The write also returns the transmit write pointer to 0.
- R10: Each write to 0x20 stores `host_wdata[7:0]`. When the number of bytes written equals the programmed count, or reaches `MAX_FRAME`, that many bytes are emitted on consecutive cycles from the next cycle on, with `txs_last` on the final byte. In the same step the count and pointer clear, transmit-done is set and busy becomes 1.
- R11: Writes to 0x20 made while a frame is being emitted are ignored. Writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change no state.
- R12: After `rst_n`, busy is 1, both counts are 0 and all interrupt bits are 0. A soft reset does the same except that the test bit is set. Receive stays blocked until the host writes 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Register access request, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address, low 6 bits decoded |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| host_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt |
| rxs_valid | input | 1 | Receive beat valid |
| rxs_sof | input | 1 | First beat of a frame |
| rxs_eof | input | 1 | Last beat of a frame |
| rxs_data | input | 8 | Receive byte |
| rxs_ready | output | 1 | A frame starting now will be stored |
| txs_valid | output | 1 | Transmit byte valid |
| txs_data | output | 8 | Transmit byte |
| txs_last | output | 1 | Final byte of the frame |
| rx_drop_count | output | DROP_W | Saturating count of dropped receive frames |

## Verification
Register side effects land on the clock edge that takes the request. Read data shows up on the next edge. The bench drives each access at a falling edge and samples at the following falling edge, which is exactly one cycle later. A receive frame is committed on the edge of its end beat, so the count and interrupt reads that follow the last beat already see it. A transmit frame starts one cycle after the edge of its final data write and runs for exactly its length in cycles. The bench therefore waits the length plus a margin before it compares the captured bytes, the length and the last marker against values it computes itself.

// File: rtl/sfnic_pkg.sv
`timescale 1ns/1ps
package sfnic_pkg;

  // register offsets (low 6 address bits)
  localparam logic [5:0] OFS_ID0   = 6'h00;
  localparam logic [5:0] OFS_ID1   = 6'h04;
  localparam logic [5:0] OFS_BUSY  = 6'h08;
  localparam logic [5:0] OFS_RXCNT = 6'h0C;
  localparam logic [5:0] OFS_TXCNT = 6'h10;
  localparam logic [5:0] OFS_IRQ   = 6'h14;
  localparam logic [5:0] OFS_INFO  = 6'h18;
  localparam logic [5:0] OFS_RXDAT = 6'h1C;
  localparam logic [5:0] OFS_TXDAT = 6'h20;

  localparam logic [31:0] ID_WORD0 = 32'h4D49_5053;
  localparam logic [31:0] ID_WORD1 = 32'h4E45_5430;

  typedef struct packed {
    logic test;
    logic rx_done;
    logic tx_done;
  } irq_bits_t;

  typedef enum logic [1:0] {ICW_NONE, ICW_CLR_TX, ICW_CLR_RX, ICW_SOFT} icw_action_e;

  // prioritised decode of an interrupt-control write
  function automatic icw_action_e decode_irq_write(input logic [31:0] v);
    if (v[0])       return ICW_CLR_TX;
    else if (v[1])  return ICW_CLR_RX;
    else if (v[31]) return ICW_SOFT;
    else            return ICW_NONE;
  endfunction

  function automatic logic [31:0] pack_irq(input irq_bits_t b);
    return {b.test, 29'd0, b.rx_done, b.tx_done};
  endfunction

endpackage

// File: rtl/sfnic_rx.sv
`timescale 1ns/1ps
module sfnic_rx #(
  parameter int MAX_FRAME = 1514,
  parameter int DROP_W    = 16,
  localparam int LEN_W    = $clog2(MAX_FRAME + 1),
  localparam int IDX_W    = $clog2(MAX_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             busy,
  input  logic             s_valid,
  input  logic             s_sof,
  input  logic             s_eof,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  input  logic             pop,
  output logic [LEN_W-1:0] count,
  output logic [7:0]       rd_byte,
  output logic             commit,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);

  function automatic logic [LEN_W-1:0] next_len(input logic [LEN_W-1:0] cur);
    return (cur == MAX_L) ? MAX_L : cur + 1'b1;
  endfunction

  logic [7:0]        mem [MAX_FRAME];
  logic              cap_q;
  logic [LEN_W-1:0]  wlen_q, count_q;
  logic [IDX_W-1:0]  rptr_q;
  logic [DROP_W-1:0] drop_q;

  // named events
  logic             start, start_ok, start_drop, beat_in, end_beat;
  logic             oversize, drop_ev, pop_ok;
  logic [LEN_W-1:0] cur_len, final_len;

  assign s_ready    = ~busy & ~cap_q & (count_q < MAX_L);
  assign start      = s_valid & s_sof & ~cap_q;
  assign start_ok   = start & s_ready;
  assign start_drop = start & ~s_ready;
  assign beat_in    = s_valid & (cap_q | start_ok);
  assign end_beat   = beat_in & s_eof;
  assign cur_len    = cap_q ? wlen_q : '0;
  assign final_len  = next_len(cur_len);
  assign commit     = end_beat & (final_len < MAX_L) & ~clr;
  assign oversize   = end_beat & ~(final_len < MAX_L) & ~clr;
  assign drop_ev    = start_drop | oversize;
  assign pop_ok     = pop & (count_q != '0);

  always_ff @(posedge clk) begin
    if (beat_in && (cur_len < MAX_L)) mem[cur_len[IDX_W-1:0]] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cap_q   <= 1'b0;
      wlen_q  <= '0;
      count_q <= '0;
      rptr_q  <= '0;
    end else begin
      if (start_ok) begin
        count_q <= '0;
        rptr_q  <= '0;
      end else if (pop_ok) begin
        count_q <= count_q - 1'b1;
        rptr_q  <= rptr_q + 1'b1;
      end
      if (beat_in) begin
        if (s_eof) begin
          cap_q  <= 1'b0;
          wlen_q <= '0;
          if (commit) begin
            count_q <= final_len;
            rptr_q  <= '0;
          end
        end else begin
          cap_q  <= 1'b1;
          wlen_q <= final_len;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= '0;
    else if (drop_ev && (drop_q != '1)) drop_q <= drop_q + 1'b1;
  end

  assign count      = count_q;
  assign rd_byte    = mem[rptr_q];
  assign drop_count = drop_q;

  // R8: a draining read lowers the count by exactly one
  p_pop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !clr && !start_ok) |=> (count_q == $past(count_q) - 1'b1));
  // R7: the drop counter never wraps
  p_drop_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q == '1) |=> (drop_q == '1));
  // R7: a stored frame is nonempty and shorter than the limit
  p_commit_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ((count_q != '0) && (count_q < MAX_L)));

endmodule

// File: rtl/sfnic_tx.sv
`timescale 1ns/1ps
module sfnic_tx #(
  parameter int MAX_FRAME = 1514,
  localparam int LEN_W    = $clog2(MAX_FRAME + 1),
  localparam int IDX_W    = $clog2(MAX_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld_count,
  input  logic [31:0]      ld_value,
  input  logic             wr_byte,
  input  logic [7:0]       wr_data,
  output logic [LEN_W-1:0] count,
  output logic             fire,
  output logic             m_valid,
  output logic [7:0]       m_data,
  output logic             m_last
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);

  function automatic logic [LEN_W-1:0] clamp_count(input logic [31:0] v);
    return (v <= 32'(MAX_FRAME)) ? v[LEN_W-1:0] : '0;
  endfunction

  logic [7:0]       mem [MAX_FRAME];
  logic [LEN_W-1:0] cnt_q, wptr_q, olen_q, oidx_q, nxt;
  logic             emit_q, wr_ok, last_beat;

  assign wr_ok     = wr_byte & ~emit_q;
  assign nxt       = wptr_q + 1'b1;
  assign fire      = wr_ok & ((nxt >= MAX_L) | (nxt == cnt_q));
  assign last_beat = emit_q & (oidx_q == olen_q - 1'b1);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      emit_q <= 1'b0;
      olen_q <= '0;
      oidx_q <= '0;
    end else begin
      if (clr) begin
        cnt_q  <= '0;
        wptr_q <= '0;
      end else if (ld_count) begin
        cnt_q  <= clamp_count(ld_value);
        wptr_q <= '0;
      end else if (wr_ok) begin
        if (fire) begin
          cnt_q  <= '0;
          wptr_q <= '0;
        end else begin
          wptr_q <= nxt;
        end
      end
      if (fire) begin
        emit_q <= 1'b1;
        olen_q <= nxt;
        oidx_q <= '0;
      end else if (emit_q) begin
        if (last_beat) emit_q <= 1'b0;
        else           oidx_q <= oidx_q + 1'b1;
      end
    end
  end

  assign count   = cnt_q;
  assign m_valid = emit_q;
  assign m_data  = mem[oidx_q[IDX_W-1:0]];
  assign m_last  = last_beat;

  // R10: emission of a frame always ends before the next can start
  p_last_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_last) |=> !m_valid);
  // R11: data writes during emission leave the write pointer alone
  p_emit_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_q && wr_byte) |=> (wptr_q == $past(wptr_q)));
  // R10: a send clears count and pointer and starts the stream
  p_fire_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((wptr_q == '0) && (cnt_q == '0) && m_valid));

endmodule

// File: rtl/sfnic_top.sv
`timescale 1ns/1ps
module sfnic_top
  import sfnic_pkg::*;
#(
  parameter int MAX_FRAME = 1514,
  parameter int ADDR_W    = 8,
  parameter int DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic              host_rvalid,
  output logic [31:0]       host_rdata,
  output logic              irq,
  input  logic              rxs_valid,
  input  logic              rxs_sof,
  input  logic              rxs_eof,
  input  logic [7:0]        rxs_data,
  output logic              rxs_ready,
  output logic              txs_valid,
  output logic [7:0]        txs_data,
  output logic              txs_last,
  output logic [DROP_W-1:0] rx_drop_count
);
  localparam int LEN_W = $clog2(MAX_FRAME + 1);

  logic [5:0] ofs;
  logic       unused_addr_hi;
  assign ofs            = host_addr[5:0];
  assign unused_addr_hi = ^host_addr;

  // named access events
  logic        rd, wr, wr_txcnt, wr_txdat, wr_irq, rd_irq, rd_rxdat, soft_rst;
  icw_action_e icw;
  assign rd       = host_req & ~host_we;
  assign wr       = host_req &  host_we;
  assign wr_txcnt = wr & (ofs == OFS_TXCNT);
  assign wr_txdat = wr & (ofs == OFS_TXDAT);
  assign wr_irq   = wr & (ofs == OFS_IRQ);
  assign rd_irq   = rd & (ofs == OFS_IRQ);
  assign rd_rxdat = rd & (ofs == OFS_RXDAT);
  assign icw      = decode_irq_write(host_wdata);
  assign soft_rst = wr_irq & (icw == ICW_SOFT);

  irq_bits_t        irq_q, irq_n;
  logic             busy_q, busy_n;
  logic             rx_commit, tx_fire;
  logic [LEN_W-1:0] rx_count, tx_count;
  logic [7:0]       rx_byte;

  sfnic_rx #(.MAX_FRAME(MAX_FRAME), .DROP_W(DROP_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .busy(busy_q),
    .s_valid(rxs_valid), .s_sof(rxs_sof), .s_eof(rxs_eof), .s_data(rxs_data),
    .s_ready(rxs_ready), .pop(rd_rxdat), .count(rx_count), .rd_byte(rx_byte),
    .commit(rx_commit), .drop_count(rx_drop_count)
  );

  sfnic_tx #(.MAX_FRAME(MAX_FRAME)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .ld_count(wr_txcnt), .ld_value(host_wdata),
    .wr_byte(wr_txdat), .wr_data(host_wdata[7:0]),
    .count(tx_count), .fire(tx_fire),
    .m_valid(txs_valid), .m_data(txs_data), .m_last(txs_last)
  );

  always_comb begin
    irq_n  = irq_q;
    busy_n = busy_q;
    if (rd_irq) irq_n.test = 1'b0;
    if (wr_irq) begin
      case (icw)
        ICW_CLR_TX: irq_n.tx_done = 1'b0;
        ICW_CLR_RX: irq_n.rx_done = 1'b0;
        ICW_SOFT: begin
          irq_n      = '0;
          irq_n.test = 1'b1;
        end
        default: ;
      endcase
      busy_n = |irq_n;
    end
    if (tx_fire) begin
      irq_n.tx_done = 1'b1;
      busy_n        = 1'b1;
    end
    if (rx_commit) begin
      irq_n.rx_done = 1'b1;
      busy_n        = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      busy_q <= 1'b1;
    end else begin
      irq_q  <= irq_n;
      busy_q <= busy_n;
    end
  end

  assign irq = |irq_q;

  logic [31:0] rd_mux;
  always_comb begin
    case (ofs)
      OFS_ID0:   rd_mux = ID_WORD0;
      OFS_ID1:   rd_mux = ID_WORD1;
      OFS_BUSY:  rd_mux = {31'd0, busy_q};
      OFS_RXCNT: rd_mux = {{(32-LEN_W){1'b0}}, rx_count};
      OFS_TXCNT: rd_mux = {{(32-LEN_W){1'b0}}, tx_count};
      OFS_IRQ:   rd_mux = pack_irq(irq_q);
      OFS_RXDAT: rd_mux = (rx_count != '0) ? {24'd0, rx_byte} : 32'd0;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd;
      if (rd) host_rdata <= rd_mux;
    end
  end

  // R2: read data is valid exactly one cycle after a read request
  p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> host_rvalid);
  p_no_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !host_rvalid);
  // R6: a stored frame raises receive-done and busy
  p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_commit |=> (busy_q && irq_q.rx_done));
  // R6: no frame is offered a slot while busy
  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rxs_ready |-> !busy_q);
  // R10: a send raises transmit-done and busy
  p_fire_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (busy_q && irq_q.tx_done));
  // R12: soft reset leaves only the test bit and busy
  p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (busy_q && irq_q.test && !irq_q.tx_done && !irq_q.rx_done));
  // R5: reading interrupt control drops the test bit
  p_test_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_irq |=> !irq_q.test);

endmodule

// File: tb/tb_sfnic_top.sv
`timescale 1ns/1ps
module tb_sfnic_top;
  localparam int MAXF = 16;
  localparam logic [7:0] A_ID0 = 8'h00, A_ID1 = 8'h04, A_BUSY = 8'h08, A_RXC = 8'h0C,
                         A_TXC = 8'h10, A_IRQ = 8'h14, A_INFO = 8'h18, A_RXD = 8'h1C,
                         A_TXD = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [7:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_rvalid, irq, rxs_ready, txs_valid, txs_last;
  logic [31:0] host_rdata;
  logic rxs_valid = 1'b0, rxs_sof = 1'b0, rxs_eof = 1'b0;
  logic [7:0] rxs_data = '0, txs_data;
  logic [15:0] rx_drop_count;

  always #5 clk = ~clk;

  sfnic_top #(.MAX_FRAME(MAXF), .ADDR_W(8), .DROP_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .irq(irq), .rxs_valid(rxs_valid), .rxs_sof(rxs_sof),
    .rxs_eof(rxs_eof), .rxs_data(rxs_data), .rxs_ready(rxs_ready),
    .txs_valid(txs_valid), .txs_data(txs_data), .txs_last(txs_last),
    .rx_drop_count(rx_drop_count)
  );

  int checks = 0, errors = 0, exp_drop = 0, cyc = 0;
  bit done = 1'b0;

  // transmit stream capture
  logic [7:0] txcap [32];
  int txn = 0, tx_frames = 0, tx_len = 0;
  always @(negedge clk) begin
    if (rst_n && txs_valid) begin
      txcap[txn] = txs_data;
      txn++;
      if (txs_last) begin
        tx_frames++;
        tx_len = txn;
        txn = 0;
      end
    end
  end

  function automatic logic [7:0] rxb(input int seed, input int i);
    return 8'((seed * 31 + i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] txb(input int seed, input int i);
    return 8'((seed * 17 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    chk("R2 rvalid", {31'd0, host_rvalid}, 32'd1);
    chk(tag, host_rdata, exp);
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxs_valid = 1'b1; rxs_sof = (i == 0); rxs_eof = (i == len - 1); rxs_data = rxb(seed, i);
    end
    @(negedge clk);
    rxs_valid = 1'b0; rxs_sof = 1'b0; rxs_eof = 1'b0;
  endtask

  task automatic send_tx(input int n, input int seed);
    wr(A_TXC, n);
    for (int i = 0; i < n; i++) wr(A_TXD, 32'hABCD_0000 | 32'(txb(seed, i)));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 irq after reset", {31'd0, irq}, 0);
    chk("R12 rx ready after reset", {31'd0, rxs_ready}, 0);
    chk("R2 rvalid idle", {31'd0, host_rvalid}, 0);
    rd_chk(A_BUSY, 1, "R12 busy after reset");
    rd_chk(A_RXC, 0, "R12 rx count after reset");
    rd_chk(A_TXC, 0, "R12 tx count after reset");
    rd_chk(A_IRQ, 0, "R12 intctl after reset");
    @(negedge clk);
    chk("R2 rvalid drops", {31'd0, host_rvalid}, 0);
    // R1 identification and zero registers, aliasing
    rd_chk(A_ID0, 32'h4D495053, "R1 id0");
    rd_chk(A_ID1, 32'h4E455430, "R1 id1");
    rd_chk(8'h40, 32'h4D495053, "R1 id0 alias");
    rd_chk(8'h44, 32'h4E455430, "R1 id1 alias");
    rd_chk(A_INFO, 0, "R1 info");
    rd_chk(A_TXD, 0, "R1 tx data reads zero");
    rd_chk(8'h24, 0, "R1 unmapped");
    // R11 read-only registers ignore writes
    wr(A_BUSY, 0); wr(A_RXC, 5); wr(A_ID0, 0); wr(A_INFO, 7); wr(A_RXD, 9);
    rd_chk(A_BUSY, 1, "R11 busy unchanged");
    rd_chk(A_RXC, 0, "R11 rx count unchanged");
    rd_chk(A_ID0, 32'h4D495053, "R11 id unchanged");
    // R6/R7 frame while busy is dropped
    send_frame(3, 1); exp_drop++;
    chk("R7 drop while busy", {16'd0, rx_drop_count}, exp_drop);
    rd_chk(A_RXC, 0, "R6 no store while busy");
    // R4 write zero recomputes busy
    wr(A_IRQ, 0);
    rd_chk(A_BUSY, 0, "R4 busy after zero write");
    chk("R6 ready when idle", {31'd0, rxs_ready}, 1);
    // R6/R8 receive sweep
    for (int len = 1; len < MAXF; len++) begin
      send_frame(len, len);
      chk("R6 ready low after accept", {31'd0, rxs_ready}, 0);
      rd_chk(A_RXC, len, "R6 rx count");
      rd_chk(A_BUSY, 1, "R6 busy after accept");
      rd_chk(A_IRQ, 2, "R3 rx done bit");
      chk("R3 irq high", {31'd0, irq}, 1);
      for (int i = 0; i < len; i++) begin
        rd_chk(A_RXD, {24'd0, rxb(len, i)}, "R8 rx byte");
        if (i == 0) rd_chk(A_RXC, len - 1, "R8 count decrement");
      end
      rd_chk(A_RXD, 0, "R8 empty read");
      rd_chk(A_RXC, 0, "R8 empty count stays");
      wr(A_IRQ, 2);
      rd_chk(A_IRQ, 0, "R4 rx done cleared");
      rd_chk(A_BUSY, 0, "R4 busy recomputed");
      chk("R3 irq low", {31'd0, irq}, 0);
    end
    // R7 oversize frames
    send_frame(MAXF, 3); exp_drop++;
    chk("R7 drop at limit", {16'd0, rx_drop_count}, exp_drop);
    send_frame(MAXF + 4, 4); exp_drop++;
    chk("R7 drop above limit", {16'd0, rx_drop_count}, exp_drop);
    rd_chk(A_RXC, 0, "R7 nothing stored");
    rd_chk(A_BUSY, 0, "R7 busy unchanged");
    // R6 second frame while first pending
    send_frame(2, 5);
    send_frame(4, 6); exp_drop++;
    chk("R6 second frame dropped", {16'd0, rx_drop_count}, exp_drop);
    rd_chk(A_RXC, 2, "R6 first frame kept");
    rd_chk(A_RXD, {24'd0, rxb(5, 0)}, "R6 first frame byte");
    rd_chk(A_RXD, {24'd0, rxb(5, 1)}, "R6 first frame byte");
    wr(A_IRQ, 2);
    // R9/R10 transmit sweep
    for (int n = 1; n <= MAXF; n++) begin
      f0 = tx_frames;
      wr(A_TXC, n);
      rd_chk(A_TXC, n, "R9 tx count load");
      for (int i = 0; i < n; i++) wr(A_TXD, 32'hABCD_0000 | 32'(txb(n, i)));
      repeat (n + 2) @(negedge clk);
      chk("R10 one frame sent", tx_frames, f0 + 1);
      chk("R10 frame length", tx_len, n);
      for (int i = 0; i < n; i++) chk("R10 tx byte", {24'd0, txcap[i]}, {24'd0, txb(n, i)});
      rd_chk(A_IRQ, 1, "R10 tx done");
      rd_chk(A_BUSY, 1, "R10 busy after send");
      rd_chk(A_TXC, 0, "R10 count cleared");
      wr(A_IRQ, 1);
      rd_chk(A_BUSY, 0, "R4 tx done cleared busy");
    end
    // R9 over-limit count loads zero; R10 send at limit
    wr(A_TXC, MAXF + 1);
    rd_chk(A_TXC, 0, "R9 over limit loads zero");
    f0 = tx_frames;
    for (int i = 0; i < MAXF; i++) wr(A_TXD, 32'(txb(99, i)));
    repeat (MAXF + 2) @(negedge clk);
    chk("R10 send at limit", tx_frames, f0 + 1);
    chk("R10 limit length", tx_len, MAXF);
    wr(A_IRQ, 1);
    // R11 data writes during emission are ignored
    f0 = tx_frames;
    send_tx(8, 7);
    wr(A_TXD, 32'h55); wr(A_TXD, 32'h66);
    repeat (10) @(negedge clk);
    send_tx(2, 8);
    repeat (4) @(negedge clk);
    chk("R11 frames after ignored writes", tx_frames, f0 + 2);
    chk("R11 clean length", tx_len, 2);
    chk("R11 clean byte0", {24'd0, txcap[0]}, {24'd0, txb(8, 0)});
    chk("R11 clean byte1", {24'd0, txcap[1]}, {24'd0, txb(8, 1)});
    wr(A_IRQ, 1);
    rd_chk(A_BUSY, 0, "R4 idle again");
    // R4 priority
    send_frame(3, 9);
    send_tx(2, 9);
    repeat (4) @(negedge clk);
    rd_chk(A_IRQ, 3, "R3 both done bits");
    wr(A_IRQ, 3);
    rd_chk(A_IRQ, 2, "R4 bit0 wins");
    rd_chk(A_BUSY, 1, "R4 busy still set");
    wr(A_IRQ, 32'h8000_0002);
    rd_chk(A_IRQ, 0, "R4 bit1 beats test");
    rd_chk(A_RXC, 3, "R4 no soft reset taken");
    rd_chk(A_BUSY, 0, "R4 busy cleared");
    // R12 soft reset
    send_frame(4, 10);
    wr(A_TXC, 5);
    wr(A_IRQ, 32'h8000_0000);
    chk("R12 irq after soft reset", {31'd0, irq}, 1);
    rd_chk(A_BUSY, 1, "R12 busy after soft reset");
    rd_chk(A_RXC, 0, "R12 rx count cleared");
    rd_chk(A_TXC, 0, "R12 tx count cleared");
    rd_chk(A_IRQ, 32'h8000_0000, "R5 test bit read");
    rd_chk(A_IRQ, 0, "R5 test bit cleared by read");
    chk("R3 irq low after test read", {31'd0, irq}, 0);
    rd_chk(A_BUSY, 1, "R12 still blocked");
    chk("R12 ready low while blocked", {31'd0, rxs_ready}, 0);
    wr(A_IRQ, 0);
    rd_chk(A_BUSY, 0, "R4 zero write unblocks");
    // R7 saturation
    send_frame(1, 11);
    @(negedge clk);
    rxs_valid = 1'b1; rxs_sof = 1'b1; rxs_eof = 1'b1;
    repeat (65540) @(negedge clk);
    rxs_valid = 1'b0; rxs_sof = 1'b0; rxs_eof = 1'b0;
    @(negedge clk);
    chk("R7 drop counter saturates", {16'd0, rx_drop_count}, 32'h0000_FFFF);
    rd_chk(A_RXC, 1, "R7 stored frame untouched");
    finish_run();
  end
endmodule